// File: doc/BRIEF.md
# Streaming Hamming Page Parity Generator

This block computes a 24-bit single-error-correcting parity code over a fixed-size chunk of data (512 bytes by default) while the bytes stream through it, one byte per accepted beat. It keeps two families of running parities. Row parities are taken over the bytes whose position in the chunk has a given index bit set or clear. Column parities are taken over the bit lanes inside each byte whose lane number has a given bit set or clear. The host pulses a clear input before each chunk. Once the chunk's final byte has been taken, the code is complete, a done flag rises, and further bytes have no effect until the next clear.

The code is built from twelve bit pairs. In pair p, the odd bit is the inverted parity of the data bits whose selected index bit is 1, and the even bit is the inverted parity of the data bits whose selected index bit is 0. Take the XOR of a stored code and a freshly computed code. After a single flipped data bit, every pair in that XOR disagrees, and the odd bits spell out the position of the bad byte and the bad bit. Because the parities are stored inverted, a blank chunk gives a code of all ones. The code can be read whole or one byte lane at a time.

Top module: `ham_page_ecc_gen`

## Requirements
- R1: After synchronous reset, code_o is 24'hFFFFFF, done_o is 0 and the byte position is 0.
- R2: A cycle with clr_i high sets code_o to 24'hFFFFFF and done_o to 0 on the next clock, and restarts the byte position at 0. A byte offered in that same cycle is dropped.
- R3: Pair p occupies code bits 2p (even) and 2p+1 (odd). For p = 0..8 the pair selects byte-position bit p. For p = 9..11 it selects in-byte bit-lane bit p-9. The odd bit is the inverted XOR of all data bits whose selected index bit is 1. The even bit is the inverted XOR of those whose selected index bit is 0.
- R4: rd_byte_o shows code_o[7:0] when rd_sel_i is 0, code_o[15:8] when it is 1 and code_o[23:16] when it is 2, and shows 8'hFF when it is 3, without waiting for a clock.
- R5: done_o rises on the clock that accepts the 512th byte since the last clear (or reset), not earlier, and stays high until a clear.
- R6: Once done_o is high, offered bytes leave code_o unchanged.
- R7: A cycle with in_valid_i low leaves code_o and the byte position unchanged, whatever in_byte_i holds.
- R8: For two chunks that differ in exactly one data bit, the XOR of their codes has every pair disagreeing. Its odd bits of pairs 0..8 give the byte position, and its odd bits of pairs 9..11 give the bit lane.
- R9: A chunk of all 8'hFF bytes and a chunk of all 8'h00 bytes both give code 24'hFFFFFF.
- R10: code_o reflects each accepted byte from the clock edge that accepts it, so after any n accepted bytes it equals the R3 code of those n bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_i | input | 1 | Clear pulse issued before each chunk |
| in_valid_i | input | 1 | A data byte is offered this cycle |
| in_byte_i | input | 8 | Offered data byte |
| rd_sel_i | input | 2 | Byte lane select for rd_byte_o |
| code_o | output | 24 | Running parity code |
| rd_byte_o | output | 8 | Selected byte lane of the code |
| done_o | output | 1 | The whole chunk has been taken |

## Verification
Each accepted byte, clear or reset acts on the rising edge that samples it, so code_o and done_o are due one edge after the stimulus. The bench drives inputs on the falling edge and samples at the next falling edge, half a period after the edge that must carry the change. The byte-lane readout is combinational, so it is sampled one nanosecond after rd_sel_i changes, with no clock in between. The done check at 511 bytes and the checks after the overflow bytes sample at the same falling-edge points, so an off-by-one in the byte count shows up as a wrong value there.

// File: rtl/hamecc_pkg.sv
package hamecc_pkg;

    localparam int unsigned LANE_BITS  = 8;
    localparam int unsigned LANE_IDX_W = 3;

    typedef struct packed {
        logic                 valid;
        logic [LANE_BITS-1:0] data;
    } beat_t;

    // Mask of the bit lanes whose lane number has bit j equal to hi.
    function automatic logic [LANE_BITS-1:0] lane_mask(input int unsigned j, input logic hi);
        logic [LANE_BITS-1:0] m;
        for (int unsigned b = 0; b < LANE_BITS; b++) begin
            m[b] = (((b >> j) & 1) == 1) == hi;
        end
        return m;
    endfunction

endpackage

// File: rtl/pecc_byte_counter.sv
module pecc_byte_counter #(
    parameter int unsigned CHUNK_BYTES = 512,
    localparam int unsigned IDX_W = $clog2(CHUNK_BYTES),
    localparam int unsigned CNT_W = $clog2(CHUNK_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             valid,
    output logic             accept,
    output logic [IDX_W-1:0] idx,
    output logic             full
);
    logic [CNT_W-1:0] count;

    assign full   = (count == CNT_W'(CHUNK_BYTES));
    assign accept = valid && !clr && !full;
    assign idx    = count[IDX_W-1:0];

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (accept) begin
            count <= count + 1'b1;
        end
    end

    // R5: every accepted byte advances the position by one
    p_step_r5: assert property (@(posedge clk) disable iff (rst)
        accept |=> (count == $past(count) + 1'b1));

    // R6: no byte is taken once the chunk is complete
    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(CHUNK_BYTES));

endmodule

// File: rtl/pecc_row_acc.sv
module pecc_row_acc #(
    parameter int unsigned IDX_W = 9
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    input  logic             byte_par,
    output logic [IDX_W-1:0] par_hi,
    output logic [IDX_W-1:0] par_lo
);
    for (genvar k = 0; k < IDX_W; k++) begin : g_row
        always_ff @(posedge clk) begin
            if (rst || clr) begin
                par_hi[k] <= 1'b0;
                par_lo[k] <= 1'b0;
            end else if (accept) begin
                par_hi[k] <= par_hi[k] ^ (byte_par &  idx[k]);
                par_lo[k] <= par_lo[k] ^ (byte_par & ~idx[k]);
            end
        end
    end

endmodule

// File: rtl/pecc_col_acc.sv
module pecc_col_acc
    import hamecc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  clr,
    input  logic                  accept,
    input  logic [LANE_BITS-1:0]  data,
    output logic [LANE_IDX_W-1:0] par_hi,
    output logic [LANE_IDX_W-1:0] par_lo
);
    // Per-lane running XOR over every accepted byte.
    logic [LANE_BITS-1:0] lane_x;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            lane_x <= '0;
        end else if (accept) begin
            lane_x <= lane_x ^ data;
        end
    end

    for (genvar j = 0; j < LANE_IDX_W; j++) begin : g_col
        assign par_hi[j] = ^(lane_x & lane_mask(j, 1'b1));
        assign par_lo[j] = ^(lane_x & lane_mask(j, 1'b0));
    end

endmodule

// File: rtl/ham_page_ecc_gen.sv
module ham_page_ecc_gen
    import hamecc_pkg::*;
#(
    parameter int unsigned CHUNK_BYTES = 512,
    localparam int unsigned IDX_W   = $clog2(CHUNK_BYTES),
    localparam int unsigned PAIRS   = IDX_W + LANE_IDX_W,
    localparam int unsigned CODE_W  = 2 * PAIRS,
    localparam int unsigned LANES   = (CODE_W + LANE_BITS - 1) / LANE_BITS,
    localparam int unsigned SEL_W   = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int unsigned PAD_W   = (1 << SEL_W) * LANE_BITS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr_i,
    input  logic                 in_valid_i,
    input  logic [LANE_BITS-1:0] in_byte_i,
    input  logic [SEL_W-1:0]     rd_sel_i,
    output logic [CODE_W-1:0]    code_o,
    output logic [LANE_BITS-1:0] rd_byte_o,
    output logic                 done_o
);
    beat_t                 beat;
    logic                  accept;
    logic [IDX_W-1:0]      idx;
    logic [IDX_W-1:0]      row_hi, row_lo;
    logic [LANE_IDX_W-1:0] col_hi, col_lo;
    logic [PAD_W-1:0]      code_pad;

    assign beat = '{valid: in_valid_i, data: in_byte_i};

    pecc_byte_counter #(.CHUNK_BYTES(CHUNK_BYTES)) u_cnt (
        .clk(clk), .rst(rst), .clr(clr_i), .valid(beat.valid),
        .accept(accept), .idx(idx), .full(done_o)
    );

    pecc_row_acc #(.IDX_W(IDX_W)) u_row (
        .clk(clk), .rst(rst), .clr(clr_i), .accept(accept),
        .idx(idx), .byte_par(^beat.data),
        .par_hi(row_hi), .par_lo(row_lo)
    );

    pecc_col_acc u_col (
        .clk(clk), .rst(rst), .clr(clr_i), .accept(accept),
        .data(beat.data), .par_hi(col_hi), .par_lo(col_lo)
    );

    // Inverted parities: a blank chunk yields all ones.
    for (genvar p = 0; p < IDX_W; p++) begin : g_row_pair
        assign code_o[2*p+1] = ~row_hi[p];
        assign code_o[2*p]   = ~row_lo[p];
    end
    for (genvar j = 0; j < LANE_IDX_W; j++) begin : g_col_pair
        assign code_o[2*(IDX_W+j)+1] = ~col_hi[j];
        assign code_o[2*(IDX_W+j)]   = ~col_lo[j];
    end

    if (PAD_W > CODE_W) begin : g_pad
        assign code_pad = {{(PAD_W-CODE_W){1'b1}}, code_o};
    end else begin : g_nopad
        assign code_pad = code_o;
    end

    assign rd_byte_o = code_pad[rd_sel_i*LANE_BITS +: LANE_BITS];

    // R2: clear returns the code to blank and drops done
    p_clear_blank_r2: assert property (@(posedge clk) disable iff (rst)
        clr_i |=> (code_o == '1) && !done_o);

    // R5 and R6: a complete chunk holds its code and flag until a clear
    p_hold_full_r6: assert property (@(posedge clk) disable iff (rst)
        done_o && !clr_i |=> done_o && $stable(code_o));

    // R7: idle cycles do not disturb the code
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !in_valid_i && !clr_i |=> $stable(code_o));

    // R8: row and column pairs agree on the total parity of the data
    for (genvar p = 1; p < PAIRS; p++) begin : g_pair_chk
        p_pair_balance_r8: assert property (@(posedge clk) disable iff (rst)
            (code_o[2*p] ^ code_o[2*p+1]) == (code_o[0] ^ code_o[1]));
    end

endmodule

// File: tb/ham_page_ecc_gen_tb_top.sv
module ham_page_ecc_gen_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        clr_i = 1'b0;
    logic        in_valid_i = 1'b0;
    logic [7:0]  in_byte_i = 8'h00;
    logic [1:0]  rd_sel_i = 2'd0;
    logic [23:0] code_o;
    logic [7:0]  rd_byte_o;
    logic        done_o;

    int vectors = 0;
    int misses  = 0;
    logic [7:0] mem [0:511];

    always #4 clk = ~clk;

    ham_page_ecc_gen dut_i (
        .clk(clk), .rst(rst), .clr_i(clr_i), .in_valid_i(in_valid_i),
        .in_byte_i(in_byte_i), .rd_sel_i(rd_sel_i), .code_o(code_o),
        .rd_byte_o(rd_byte_o), .done_o(done_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            misses++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Independent code model over the first n bytes of mem (R3).
    function automatic logic [23:0] model(input int n);
        logic [11:0] hi = '0, lo = '0;
        logic [23:0] c;
        for (int i = 0; i < n; i++) begin
            for (int b = 0; b < 8; b++) begin
                if (mem[i][b]) begin
                    for (int p = 0; p < 9; p++)
                        if ((i >> p) & 1) hi[p] = ~hi[p]; else lo[p] = ~lo[p];
                    for (int j = 0; j < 3; j++)
                        if ((b >> j) & 1) hi[9+j] = ~hi[9+j]; else lo[9+j] = ~lo[9+j];
                end
            end
        end
        for (int p = 0; p < 12; p++) begin
            c[2*p+1] = ~hi[p];
            c[2*p]   = ~lo[p];
        end
        return c;
    endfunction

    task automatic push(input logic [7:0] d);
        in_valid_i = 1'b1;
        in_byte_i  = d;
        @(negedge clk);
        in_valid_i = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_i = 1'b1;
        @(negedge clk);
        clr_i = 1'b0;
    endtask

    task automatic send_chunk();
        for (int i = 0; i < 512; i++) push(mem[i]);
    endtask

    task automatic t_reset();
        check("R1 code", 32'(code_o), 32'hFFFFFF);
        check("R1 done", 32'(done_o), 32'h0);
        for (int s = 0; s < 4; s++) begin
            rd_sel_i = 2'(s);
            #1;
            check("R1 lane", 32'(rd_byte_o), 32'hFF);
        end
        rd_sel_i = 2'd0;
    endtask

    task automatic t_blank();
        for (int i = 0; i < 512; i++) mem[i] = 8'hFF;
        pulse_clr();
        send_chunk();
        check("R9 all ones", 32'(code_o), 32'hFFFFFF);
        check("R5 done", 32'(done_o), 32'h1);
        for (int i = 0; i < 512; i++) mem[i] = 8'h00;
        pulse_clr();
        send_chunk();
        check("R9 all zeros", 32'(code_o), 32'hFFFFFF);
    endtask

    task automatic t_pattern();
        logic [23:0] exp;
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 29 + (i >> 2) * 7 + 3);
        pulse_clr();
        check("R2 clear", 32'(code_o), 32'hFFFFFF);
        send_chunk();
        exp = model(512);
        check("R3 full chunk", 32'(code_o), 32'(exp));
        for (int s = 0; s < 4; s++) begin
            rd_sel_i = 2'(s);
            #1;
            check("R4 lane", 32'(rd_byte_o), (s == 3) ? 32'hFF : 32'(exp[s*8 +: 8]));
        end
        rd_sel_i = 2'd0;
    endtask

    task automatic t_overflow();
        logic [23:0] held;
        held = code_o;
        for (int i = 0; i < 5; i++) push(8'h01 << i);
        check("R6 code held", 32'(code_o), 32'(held));
        check("R5 done held", 32'(done_o), 32'h1);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 512; i++) mem[i] = 8'(i ^ (i >> 3) ^ 8'h5A);
        pulse_clr();
        push(mem[0]);
        check("R10 first byte", 32'(code_o), 32'(model(1)));
        for (int i = 1; i < 100; i++) begin
            push(mem[i]);
            in_byte_i = 8'hC3;
            @(negedge clk);
        end
        check("R7 gaps", 32'(code_o), 32'(model(100)));
        check("R5 not done", 32'(done_o), 32'h0);
    endtask

    task automatic t_clear_collide();
        clr_i = 1'b1;
        in_valid_i = 1'b1;
        in_byte_i = 8'hA5;
        @(negedge clk);
        clr_i = 1'b0;
        in_valid_i = 1'b0;
        check("R2 collide code", 32'(code_o), 32'hFFFFFF);
        check("R2 collide done", 32'(done_o), 32'h0);
        for (int i = 0; i < 511; i++) push(mem[i]);
        check("R5 at 511", 32'(done_o), 32'h0);
        push(mem[511]);
        check("R5 at 512", 32'(done_o), 32'h1);
        check("R2 dropped byte", 32'(code_o), 32'(model(512)));
    endtask

    task automatic t_single_error();
        logic [23:0] a, b, syn;
        logic [8:0]  pos;
        for (int i = 0; i < 512; i++) mem[i] = 8'(i * 113 + 17);
        pulse_clr();
        send_chunk();
        a = code_o;
        mem[300][5] = ~mem[300][5];
        pulse_clr();
        send_chunk();
        b = code_o;
        syn = a ^ b;
        check("R8 pairs", 32'((syn ^ (syn >> 1)) & 24'h555555), 32'h555555);
        for (int p = 0; p < 9; p++) pos[p] = syn[2*p+1];
        check("R8 byte", 32'(pos), 32'd300);
        check("R8 bit", 32'({syn[23], syn[21], syn[19]}), 32'd5);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_blank();
        t_pattern();
        t_overflow();
        t_gaps();
        t_clear_collide();
        t_single_error();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        vectors++;
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    end

endmodule